// File: doc/BRIEF.md
# Burst RX FIFO Unload Port

This block is the read side of a four-channel serial receive path. Each channel keeps a queue of received characters. Every entry pairs an 8-bit data byte with the 8-bit line status recorded for that byte. A producer fills the queues through a simple per-channel push interface. A 32-bit read bus drains them. The read bus is a valid/address/byte-enable request that gets a response one cycle later, and it stands in for a host bus.

The read address selects a channel and one of three views onto that channel's queue:
- The holding view hands out a single byte per read.
- The packed view returns up to four consecutive bytes in one 32-bit word, so a full queue drains in 16 word reads.
- The status view places each byte's line status next to its data, two characters per word, so a full queue drains in 32 word reads.

Every read removes exactly as many entries as it delivered. The byte enables decide how many that is, and so does the number of entries actually held.

The read path is run by a two-state machine. In `RD_IDLE` no response is presented. In `RD_REPLY` the response to the previous cycle's request is on the bus. The transition out of either state is decided only by `rd_valid`:
- A request moves the machine to `RD_REPLY`, or keeps it there.
- A cycle without a request moves it to `RD_IDLE`, or keeps it there.

Top module: `rx_burst_unload`

## Requirements
- R1: After reset all queues are empty, `push_full` is all zero, `rd_ack` is 0 and `rd_data` is 0.
- R2: Each queue holds 64 entries. `push_full` for a channel is 1 exactly when its queue holds 64 entries. A push to a full queue is dropped. A full queue stays full until that channel is read.
- R3: `rd_addr[10:9]` selects the channel. Within a channel, offset bits [8:0] select the view:
  - the holding view is at offset 0x000;
  - the packed view is at offsets 0x100–0x17F;
  - the status view is at offsets 0x180–0x1FF.
  Every other offset returns 0 and removes no entry.
- R4: `rd_ack` is 1 in the cycle after each cycle with `rd_valid` = 1, and 0 otherwise. `rd_data` is 0 whenever `rd_ack` is 0.
- R5: A holding-view read with any byte enable set returns the oldest data byte in bits [7:0], with the other bits 0, and removes one entry. With no enable set it returns 0 and removes nothing.
- R6: A packed-view read gives each enabled lane k the entry at position (number of enabled lanes below k) counting from the oldest entry. Disabled lanes return 0. The read removes one entry per enabled lane. With all four enables set, lane 0 holds the oldest byte n, and lanes 1, 2 and 3 hold n+1, n+2 and n+3.
- R7: In the status view, lanes 0 and 1 form one pair and lanes 2 and 3 form another. A pair is requested only when both of its enables are set. With all four enables set, the lanes are:
  - lane 0: status of entry n;
  - lane 1: data of entry n;
  - lane 2: status of entry n+1;
  - lane 3: data of entry n+1.
  The read removes one entry per requested pair.
- R8: A status-view pair with only one of its two enables set returns 0 in both of its lanes and removes no entry. If only the upper pair is requested, it carries the oldest entry.
- R9: When a queue holds fewer entries than a read requests, the lanes without an entry return 0 and only the held entries are removed.
- R10: Reads of one channel neither return nor remove entries of another channel.
- R11: A push and a read of the same channel in the same cycle both take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| push_valid | input | 4 | Per-channel push strobe |
| push_data | input | 32 | Received byte, 8 bits per channel (channel c at [8c+7:8c]) |
| push_status | input | 32 | Line status of that byte, 8 bits per channel |
| push_full | output | 4 | Per-channel queue-full flag |
| rd_valid | input | 1 | Read request |
| rd_addr | input | 11 | Read byte address (bits [1:0] ignored) |
| rd_be | input | 4 | Read byte-lane enables |
| rd_ack | output | 1 | Response valid, one cycle after the request |
| rd_data | output | 32 | Response word |

## Verification
The bound checker watches four things on every cycle:
- the one-cycle request-to-response relationship, and a zero data bus while idle;
- zero data for undecoded offsets and for half-enabled status pairs;
- the bound of two removed entries per status read and one per holding read;
- that a full flag never drops without a read.

The directed scenarios are the only way to show what the lanes actually carry:
- the ordering of bytes across lanes and across successive burst reads;
- interleaved status placement;
- zero-filling of short queues;
- the dropped 65th push;
- isolation between channels;
- simultaneous push and pop.

// File: rtl/rxu_pkg.sv
package rxu_pkg;

    localparam int LANES  = 4;
    localparam int BLK_W  = 9;

    typedef enum logic [1:0] {
        WIN_NONE,
        WIN_HOLD,
        WIN_PACK,
        WIN_STAT
    } win_e;

    typedef enum logic {
        RD_IDLE,
        RD_REPLY
    } rd_state_e;

    typedef struct packed {
        logic [7:0] stat;
        logic [7:0] data;
    } rx_ent_t;

endpackage

// File: rtl/rxu_chan_fifo.sv
module rxu_chan_fifo
    import rxu_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int PEEK  = 4,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1),
    localparam int TAK_W = $clog2(PEEK + 1)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    push_en,
    input  rx_ent_t                 push_ent,
    input  logic [TAK_W-1:0]        pop_n,
    output rx_ent_t [PEEK-1:0]      peek,
    output logic [CNT_W-1:0]        level,
    output logic                    full
);

    rx_ent_t          mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr;
    logic [PTR_W-1:0] rd_ptr;
    logic [CNT_W-1:0] level_q;
    logic             accept;

    assign full   = (level_q == CNT_W'(DEPTH));
    assign accept = push_en && !full;
    assign level  = level_q;

    always_ff @(posedge clk) begin
        if (accept) begin
            mem[wr_ptr] <= push_ent;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr  <= '0;
            rd_ptr  <= '0;
            level_q <= '0;
        end else begin
            if (accept) begin
                wr_ptr <= wr_ptr + PTR_W'(1);
            end
            rd_ptr  <= rd_ptr + PTR_W'(pop_n);
            level_q <= level_q + CNT_W'(accept) - CNT_W'(pop_n);
        end
    end

    for (genvar i = 0; i < PEEK; i++) begin : g_peek
        assign peek[i] = mem[rd_ptr + PTR_W'(i)];
    end

endmodule

// File: rtl/rxu_addr_decode.sv
module rxu_addr_decode
    import rxu_pkg::*;
#(
    parameter int CHANNELS = 4,
    localparam int CH_W   = $clog2(CHANNELS),
    localparam int ADDR_W = BLK_W + CH_W
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [CH_W-1:0]   chan,
    output win_e              win
);

    logic [BLK_W-1:0] offs;

    assign chan = addr[ADDR_W-1:BLK_W];
    assign offs = addr[BLK_W-1:0];

    always_comb begin
        unique case (offs[8:7])
            2'b10:   win = WIN_PACK;
            2'b11:   win = WIN_STAT;
            2'b00:   win = (offs[6:2] == 5'd0) ? WIN_HOLD : WIN_NONE;
            default: win = WIN_NONE;
        endcase
    end

endmodule

// File: rtl/rxu_lane_pack.sv
module rxu_lane_pack
    import rxu_pkg::*;
#(
    parameter int DEPTH = 64,
    localparam int CNT_W = $clog2(DEPTH + 1),
    localparam int TAK_W = $clog2(LANES + 1)
) (
    input  win_e                   win,
    input  logic [LANES-1:0]       be,
    input  rx_ent_t [LANES-1:0]    peek,
    input  logic [CNT_W-1:0]       level,
    output logic [8*LANES-1:0]     word,
    output logic [TAK_W-1:0]       take
);

    always_comb begin
        int slot;
        int avail;
        word  = '0;
        slot  = 0;
        avail = int'(level);
        unique case (win)
            WIN_HOLD: begin
                if ((|be) && avail > 0) begin
                    word[7:0] = peek[0].data;
                    slot      = 1;
                end
            end
            WIN_PACK: begin
                for (int k = 0; k < LANES; k++) begin
                    if (be[k]) begin
                        if (slot < avail) begin
                            word[8*k +: 8] = peek[slot].data;
                        end
                        slot = slot + 1;
                    end
                end
            end
            WIN_STAT: begin
                for (int p = 0; p < LANES/2; p++) begin
                    if (be[2*p] && be[2*p+1]) begin
                        if (slot < avail) begin
                            word[16*p +: 8]     = peek[slot].stat;
                            word[16*p + 8 +: 8] = peek[slot].data;
                        end
                        slot = slot + 1;
                    end
                end
            end
            default: begin
                slot = 0;
            end
        endcase
        if (slot > avail) begin
            slot = avail;
        end
        take = TAK_W'(slot);
    end

endmodule

// File: rtl/rx_burst_unload.sv
module rx_burst_unload
    import rxu_pkg::*;
#(
    parameter int CHANNELS = 4,
    parameter int DEPTH    = 64
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic [CHANNELS-1:0]             push_valid,
    input  logic [8*CHANNELS-1:0]           push_data,
    input  logic [8*CHANNELS-1:0]           push_status,
    output logic [CHANNELS-1:0]             push_full,
    input  logic                            rd_valid,
    input  logic [$clog2(CHANNELS)+8:0]     rd_addr,
    input  logic [3:0]                      rd_be,
    output logic                            rd_ack,
    output logic [31:0]                     rd_data
);

    localparam int CH_W  = $clog2(CHANNELS);
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam int TAK_W = $clog2(LANES + 1);

    rd_state_e              state_q;
    rd_state_e              state_nxt;
    logic [CH_W-1:0]        sel_ch;
    win_e                   sel_win;
    rx_ent_t [LANES-1:0]    peek_all  [CHANNELS];
    logic [CNT_W-1:0]       level_all [CHANNELS];
    rx_ent_t [LANES-1:0]    peek_sel;
    logic [CNT_W-1:0]       level_sel;
    logic [8*LANES-1:0]     word;
    logic [TAK_W-1:0]       take_cnt;
    logic [31:0]            reply_q;

    rxu_addr_decode #(.CHANNELS(CHANNELS)) u_dec (
        .addr (rd_addr),
        .chan (sel_ch),
        .win  (sel_win)
    );

    for (genvar c = 0; c < CHANNELS; c++) begin : g_chan
        rx_ent_t          ent;
        logic [TAK_W-1:0] pop_c;

        assign ent.data = push_data[8*c +: 8];
        assign ent.stat = push_status[8*c +: 8];
        assign pop_c    = (rd_valid && sel_ch == CH_W'(c)) ? take_cnt : '0;

        rxu_chan_fifo #(.DEPTH(DEPTH), .PEEK(LANES)) u_fifo (
            .clk      (clk),
            .rst_n    (rst_n),
            .push_en  (push_valid[c]),
            .push_ent (ent),
            .pop_n    (pop_c),
            .peek     (peek_all[c]),
            .level    (level_all[c]),
            .full     (push_full[c])
        );
    end

    assign peek_sel  = peek_all[sel_ch];
    assign level_sel = level_all[sel_ch];

    rxu_lane_pack #(.DEPTH(DEPTH)) u_pack (
        .win   (sel_win),
        .be    (rd_be),
        .peek  (peek_sel),
        .level (level_sel),
        .word  (word),
        .take  (take_cnt)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= RD_IDLE;
            reply_q <= '0;
        end else begin
            state_q <= state_nxt;
            reply_q <= rd_valid ? word : '0;
        end
    end

    // transitions
    always_comb begin
        unique case (state_q)
            RD_IDLE:  state_nxt = rd_valid ? RD_REPLY : RD_IDLE;
            RD_REPLY: state_nxt = rd_valid ? RD_REPLY : RD_IDLE;
            default:  state_nxt = RD_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        unique case (state_q)
            RD_REPLY: begin
                rd_ack  = 1'b1;
                rd_data = reply_q;
            end
            default: begin
                rd_ack  = 1'b0;
                rd_data = '0;
            end
        endcase
    end

endmodule

// File: rtl/rxu_chk.sv
module rxu_chk #(
    parameter int CHANNELS = 4,
    localparam int CH_W = $clog2(CHANNELS)
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  rd_valid,
    input logic [CH_W+8:0]       rd_addr,
    input logic [3:0]            rd_be,
    input logic                  rd_ack,
    input logic [31:0]           rd_data,
    input logic [CHANNELS-1:0]   push_full,
    input logic [2:0]            take_cnt
);

    logic undecoded;
    logic stat_win;
    logic hold_win;

    assign undecoded = (rd_addr[8:7] == 2'b00) && (rd_addr[6:2] != 5'd0);
    assign stat_win  = (rd_addr[8:7] == 2'b11);
    assign hold_win  = (rd_addr[8:2] == 7'd0);

    // R4
    ack_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> rd_ack);

    // R4
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_valid |=> (!rd_ack && rd_data == 32'd0));

    // R3
    undec_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && undecoded) |=> (rd_data == 32'd0));

    // R8
    half_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && stat_win && rd_be[3:2] == 2'b00 && (rd_be[1] ^ rd_be[0]))
        |=> (rd_data == 32'd0));

    // R7
    stat_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && stat_win) |-> (take_cnt <= 3'd2));

    // R5
    hold_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && hold_win) |-> (take_cnt <= 3'd1));

    // R2
    full_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_valid |=> ((push_full & $past(push_full)) == $past(push_full)));

endmodule

bind rx_burst_unload rxu_chk #(.CHANNELS(CHANNELS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_valid  (rd_valid),
    .rd_addr   (rd_addr),
    .rd_be     (rd_be),
    .rd_ack    (rd_ack),
    .rd_data   (rd_data),
    .push_full (push_full),
    .take_cnt  (take_cnt)
);

// File: tb/tb_rx_burst_unload.sv
module tb_rx_burst_unload;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [3:0]  push_valid;
    logic [31:0] push_data;
    logic [31:0] push_status;
    logic [3:0]  push_full;
    logic        rd_valid;
    logic [10:0] rd_addr;
    logic [3:0]  rd_be;
    logic        rd_ack;
    logic [31:0] rd_data;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    rx_burst_unload dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .push_valid  (push_valid),
        .push_data   (push_data),
        .push_status (push_status),
        .push_full   (push_full),
        .rd_valid    (rd_valid),
        .rd_addr     (rd_addr),
        .rd_be       (rd_be),
        .rd_ack      (rd_ack),
        .rd_data     (rd_data)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%08h expected=%08h", tag, act, exp);
        end
    endtask

    task automatic push(input int ch, input logic [7:0] d, input logic [7:0] s);
        @(negedge clk);
        push_valid[ch]       = 1'b1;
        push_data[8*ch +: 8] = d;
        push_status[8*ch +: 8] = s;
        @(negedge clk);
        push_valid = '0;
    endtask

    task automatic bus_read(input logic [10:0] a, input logic [3:0] be, output logic [31:0] d);
        @(negedge clk);
        rd_valid = 1'b1;
        rd_addr  = a;
        rd_be    = be;
        @(negedge clk);
        rd_valid = 1'b0;
        d = rd_data;
        check("R4 ack", {31'd0, rd_ack}, 32'd1);
    endtask

    task automatic t_reset;
        logic [31:0] d;
        check("R1 full", {28'd0, push_full}, 32'd0);
        check("R1 ack", {31'd0, rd_ack}, 32'd0);
        check("R1 data", rd_data, 32'd0);
        bus_read(11'h100, 4'hF, d);
        check("R9 empty pack", d, 32'd0);
        @(negedge clk);
        check("R4 idle ack", {31'd0, rd_ack}, 32'd0);
        check("R4 idle data", rd_data, 32'd0);
    endtask

    task automatic t_hold;
        logic [31:0] d;
        push(0, 8'hA0, 8'h81);
        push(0, 8'hA1, 8'h82);
        push(0, 8'hA2, 8'h83);
        bus_read(11'h000, 4'h1, d);
        check("R5 hold first", d, 32'h000000A0);
        bus_read(11'h000, 4'hF, d);
        check("R5 hold wide", d, 32'h000000A1);
        bus_read(11'h000, 4'h0, d);
        check("R5 hold no enable", d, 32'd0);
        bus_read(11'h000, 4'h1, d);
        check("R5 hold kept", d, 32'h000000A2);
        bus_read(11'h000, 4'h1, d);
        check("R9 hold empty", d, 32'd0);
    endtask

    task automatic t_pack;
        logic [31:0] d;
        for (int i = 0; i < 8; i++) push(1, 8'(8'h10 + i), 8'h00);
        bus_read(11'h300, 4'hF, d);
        check("R6 pack word0", d, 32'h13121110);
        bus_read(11'h304, 4'hF, d);
        check("R6 pack word1", d, 32'h17161514);
        bus_read(11'h308, 4'hF, d);
        check("R9 pack drained", d, 32'd0);
    endtask

    task automatic t_pack_sparse;
        logic [31:0] d;
        for (int i = 0; i < 4; i++) push(2, 8'(8'h20 + i), 8'h00);
        bus_read(11'h500, 4'b0101, d);
        check("R6 sparse lanes", d, 32'h00210020);
        bus_read(11'h504, 4'hF, d);
        check("R9 short pack", d, 32'h00002322);
        bus_read(11'h508, 4'hF, d);
        check("R9 short popped", d, 32'd0);
    endtask

    task automatic t_stat;
        logic [31:0] d;
        push(3, 8'h31, 8'h01);
        push(3, 8'h32, 8'h02);
        push(3, 8'h33, 8'h03);
        bus_read(11'h780, 4'hF, d);
        check("R7 stat pairs", d, 32'h32023101);
        bus_read(11'h784, 4'b0010, d);
        check("R8 half pair", d, 32'd0);
        bus_read(11'h788, 4'b1100, d);
        check("R8 upper pair only", d, 32'h33030000);
        bus_read(11'h78C, 4'hF, d);
        check("R9 stat empty", d, 32'd0);
    endtask

    task automatic t_undecoded;
        logic [31:0] d;
        push(0, 8'h44, 8'h00);
        bus_read(11'h004, 4'hF, d);
        check("R3 undecoded zero", d, 32'd0);
        bus_read(11'h0FC, 4'hF, d);
        check("R3 undecoded high", d, 32'd0);
        bus_read(11'h000, 4'h1, d);
        check("R3 nothing popped", d, 32'h00000044);
    endtask

    task automatic t_full;
        logic [31:0] d;
        for (int i = 0; i < 64; i++) push(1, 8'(i), 8'h00);
        check("R2 full at 64", {28'd0, push_full}, 32'h2);
        push(1, 8'hEE, 8'h00);
        check("R2 still full", {28'd0, push_full}, 32'h2);
        for (int k = 0; k < 16; k++) begin
            bus_read(11'(11'h300 + 4*k), 4'hF, d);
            check("R2 drain word", d,
                  {8'(4*k+3), 8'(4*k+2), 8'(4*k+1), 8'(4*k)});
        end
        check("R2 full cleared", {28'd0, push_full}, 32'd0);
        bus_read(11'h300, 4'hF, d);
        check("R2 overflow dropped", d, 32'd0);
    endtask

    task automatic t_isolation;
        logic [31:0] d;
        push(0, 8'h55, 8'h00);
        push(2, 8'h66, 8'h00);
        bus_read(11'h500, 4'hF, d);
        check("R10 chan2 only", d, 32'h00000066);
        bus_read(11'h100, 4'hF, d);
        check("R10 chan0 intact", d, 32'h00000055);
    endtask

    task automatic t_same_cycle;
        logic [31:0] d;
        push(0, 8'h70, 8'h00);
        @(negedge clk);
        rd_valid      = 1'b1;
        rd_addr       = 11'h000;
        rd_be         = 4'h1;
        push_valid[0] = 1'b1;
        push_data[7:0] = 8'h71;
        @(negedge clk);
        rd_valid   = 1'b0;
        push_valid = '0;
        check("R11 pop side", rd_data, 32'h00000070);
        bus_read(11'h000, 4'h1, d);
        check("R11 push side", d, 32'h00000071);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        rst_n       = 1'b0;
        push_valid  = '0;
        push_data   = '0;
        push_status = '0;
        rd_valid    = 1'b0;
        rd_addr     = '0;
        rd_be       = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_hold;
        t_pack;
        t_pack_sparse;
        t_stat;
        t_undecoded;
        t_full;
        t_isolation;
        t_same_cycle;
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule